// File: doc/BRIEF.md
# Two-Step Coarse/Fine ADC Conversion Controller

This block is the digital sequencer and result assembler for a 10-bit two-step analog-to-digital converter. A sample strobe starts each conversion. In the strobe cycle the block takes the 15-wire thermometer output of a 4-bit flash stage, removes an isolated bubble and encodes the result as the 4-bit coarse value. It then hands the held residue to one of two 6-bit successive-approximation engines. Each engine drives its own trial code to an external fine DAC and comparator and resolves one bit per cycle, starting from the most significant bit.

The two engines take turns so that a new sample can start while the previous one is still converting. Accepted samples alternate between engine A and engine B. Results leave in sample order as a 10-bit word, with the coarse value in the upper four bits and the fine value in the lower six, each marked by a valid flag. A strobe that finds its target engine still occupied is discarded, and the overrun output reports it. The comparators, capacitor arrays and sample/hold switches are analog and lie outside the block.

Each engine runs a three-state machine. ENG_IDLE goes to ENG_CONVERT on an accepted start. ENG_CONVERT stays in place until the last bit is decided and then goes to ENG_DONE. ENG_DONE always returns to ENG_IDLE after one cycle, in which the result is handed to the output stage.

Top module: `twostep_adc_ctrl`

## Requirements
- R1: While rst_n is low, code_out, code_valid, overrun, sh_hold and fine_trial are all zero.
- R2: The coarse value is the number of ones in the corrected thermometer code, from 0 to 15. It is taken in the cycle the strobe is accepted and appears in code_out[9:6].
- R3: A single inverted comparator output lying at least two positions away from the thermometer's one/zero boundary does not change the coarse value. Each position is replaced by the majority of itself and its two neighbours, with a one assumed below bit 0 and a zero above bit 14.
- R4: An engine's first trial code is 6'b100000. Each cycle it decides one bit, from bit 5 down to bit 0. It keeps the bit when its fine_cmp input is 1 (residue at or above the trial level) and clears it otherwise. The final trial equals the residue, in code_out[5:0].
- R5: sh_hold[e] goes high in the cycle after engine e accepts a strobe and stays high for exactly 6 cycles.
- R6: Accepted strobes alternate between engines, the first after reset going to engine A. Engine A is index 0: sh_hold[0] and fine_trial[5:0]. Engine B is index 1: sh_hold[1] and fine_trial[11:6].
- R7: code_out = coarse*64 + fine, and code_valid is high for one cycle per accepted sample. A strobe sampled at clock edge k gives valid in the cycle after edge k+7.
- R8: Results leave in the order their strobes were accepted, with no extra or missing results.
- R9: A strobe sampled while the target engine is still busy is dropped. The target engine is busy from the edge that took its previous strobe through the seventh edge after it. overrun is high for the following cycle, no engine starts, and the next accepted strobe still goes to the same target engine.
- R10: An overrun and a result release that fall in the same cycle are both reported correctly, and an engine can take a new strobe on the edge right after it releases its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_req | input | 1 | Request to sample and convert, sampled each edge |
| flash_therm | input | 15 | Flash comparator outputs, thermometer coded, bit 0 lowest |
| fine_cmp | input | 2 | Per-engine comparator: 1 when the residue is at or above the trial |
| sh_hold | output | 2 | Per-engine sample/hold control, high while converting |
| fine_trial | output | 12 | Per-engine fine DAC trial codes, engine A in bits 5:0 |
| code_out | output | 10 | Assembled conversion result |
| code_valid | output | 1 | One-cycle marker of a new code_out |
| overrun | output | 1 | One-cycle flag for a dropped strobe |

## Verification
An engine is still busy on the edge where it holds its finished result. A strobe can therefore be dropped on the very edge where that engine's result is registered, so overrun and code_valid rise together. The bench provokes this with strobes on consecutive cycles followed by a third one seven cycles after the first. It expects the result pop and the overrun flag in the same sampled cycle. The strobe on the next cycle must then be taken by the engine that has just released its result, while the other engine releases its own result.

// File: rtl/twostep_adc_pkg.sv
package twostep_adc_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE    = 2'd0,
        ENG_CONVERT = 2'd1,
        ENG_DONE    = 2'd2
    } eng_state_t;

endpackage

// File: rtl/twostep_flash_decode.sv
module twostep_flash_decode #(
    parameter int COARSE_W = 4
) (
    input  logic [(2**COARSE_W)-2:0] therm_in,
    output logic [COARSE_W-1:0]      coarse_out
);

    localparam int THERM_W = (2**COARSE_W) - 1;

    logic [THERM_W+1:0] padded;
    logic [THERM_W-1:0] cleaned;

    // a one below the lowest comparator, a zero above the highest
    assign padded = {1'b0, therm_in, 1'b1};

    genvar g;
    generate
        for (g = 0; g < THERM_W; g++) begin : g_vote
            assign cleaned[g] = (padded[g]   & padded[g+1]) |
                                (padded[g+1] & padded[g+2]) |
                                (padded[g]   & padded[g+2]);
        end
    endgenerate

    always_comb begin
        coarse_out = '0;
        for (int i = 0; i < THERM_W; i++) begin
            coarse_out = coarse_out + COARSE_W'(cleaned[i]);
        end
    end

endmodule

// File: rtl/twostep_sar_engine.sv
module twostep_sar_engine
    import twostep_adc_pkg::*;
#(
    parameter int COARSE_W = 4,
    parameter int FINE_W   = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [COARSE_W-1:0]          coarse_in,
    input  logic                         cmp_in,
    output logic                         busy,
    output logic                         hold,
    output logic                         done,
    output logic [FINE_W-1:0]            trial,
    output logic [COARSE_W+FINE_W-1:0]   result
);

    localparam logic [FINE_W-1:0] TOP_BIT = {1'b1, {(FINE_W-1){1'b0}}};

    eng_state_t          state_q, state_d;
    logic [FINE_W-1:0]   trial_q;
    logic [FINE_W-1:0]   probe_q;
    logic [COARSE_W-1:0] coarse_q;
    logic [FINE_W-1:0]   decided;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE:    if (start)      state_d = ENG_CONVERT;
            ENG_CONVERT: if (probe_q[0]) state_d = ENG_DONE;
            ENG_DONE:                    state_d = ENG_IDLE;
            default:                     state_d = ENG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy   = (state_q != ENG_IDLE);
        hold   = (state_q == ENG_CONVERT);
        done   = (state_q == ENG_DONE);
        trial  = trial_q;
        result = {coarse_q, trial_q};
    end

    assign decided = cmp_in ? trial_q : (trial_q & ~probe_q);

    // bit-decision datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial_q  <= '0;
            probe_q  <= '0;
            coarse_q <= '0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        trial_q  <= TOP_BIT;
                        probe_q  <= TOP_BIT;
                        coarse_q <= coarse_in;
                    end
                end
                ENG_CONVERT: begin
                    trial_q <= decided | (probe_q >> 1);
                    probe_q <= probe_q >> 1;
                end
                ENG_DONE: begin
                    trial_q <= '0;
                    probe_q <= '0;
                end
                default: begin
                    trial_q <= '0;
                    probe_q <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/twostep_merge.sv
module twostep_merge #(
    parameter int NUM_ENG = 2,
    parameter int CODE_W  = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_ENG-1:0]  done_in,
    input  logic [CODE_W-1:0]   res_in [NUM_ENG],
    output logic [CODE_W-1:0]   code_out,
    output logic                code_valid
);

    localparam int PTR_W = $clog2(NUM_ENG);

    logic [PTR_W-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr     <= '0;
            code_out   <= '0;
            code_valid <= 1'b0;
        end else begin
            code_valid <= 1'b0;
            if (done_in[rd_ptr]) begin
                code_out   <= res_in[rd_ptr];
                code_valid <= 1'b1;
                if (rd_ptr == PTR_W'(NUM_ENG - 1)) rd_ptr <= '0;
                else                               rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/twostep_adc_ctrl.sv
module twostep_adc_ctrl #(
    parameter int COARSE_W = 4,
    parameter int FINE_W   = 6,
    parameter int NUM_ENG  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sample_req,
    input  logic [(2**COARSE_W)-2:0]      flash_therm,
    input  logic [NUM_ENG-1:0]            fine_cmp,
    output logic [NUM_ENG-1:0]            sh_hold,
    output logic [NUM_ENG*FINE_W-1:0]     fine_trial,
    output logic [COARSE_W+FINE_W-1:0]    code_out,
    output logic                          code_valid,
    output logic                          overrun
);

    localparam int CODE_W = COARSE_W + FINE_W;
    localparam int PTR_W  = $clog2(NUM_ENG);

    logic [COARSE_W-1:0] coarse_now;
    logic [NUM_ENG-1:0]  eng_busy;
    logic [NUM_ENG-1:0]  eng_done;
    logic [NUM_ENG-1:0]  eng_start;
    logic [CODE_W-1:0]   eng_result [NUM_ENG];
    logic [PTR_W-1:0]    wr_ptr;
    logic                accept;

    twostep_flash_decode #(.COARSE_W(COARSE_W)) u_flash (
        .therm_in   (flash_therm),
        .coarse_out (coarse_now)
    );

    assign accept = sample_req & ~eng_busy[wr_ptr];

    genvar e;
    generate
        for (e = 0; e < NUM_ENG; e++) begin : g_eng
            assign eng_start[e] = accept && (wr_ptr == PTR_W'(e));

            twostep_sar_engine #(
                .COARSE_W (COARSE_W),
                .FINE_W   (FINE_W)
            ) u_sar (
                .clk       (clk),
                .rst_n     (rst_n),
                .start     (eng_start[e]),
                .coarse_in (coarse_now),
                .cmp_in    (fine_cmp[e]),
                .busy      (eng_busy[e]),
                .hold      (sh_hold[e]),
                .done      (eng_done[e]),
                .trial     (fine_trial[e*FINE_W +: FINE_W]),
                .result    (eng_result[e])
            );
        end
    endgenerate

    // dispatch pointer and drop flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            overrun <= 1'b0;
        end else begin
            overrun <= sample_req & eng_busy[wr_ptr];
            if (accept) begin
                if (wr_ptr == PTR_W'(NUM_ENG - 1)) wr_ptr <= '0;
                else                               wr_ptr <= wr_ptr + 1'b1;
            end
        end
    end

    twostep_merge #(
        .NUM_ENG (NUM_ENG),
        .CODE_W  (CODE_W)
    ) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_in    (eng_done),
        .res_in     (eng_result),
        .code_out   (code_out),
        .code_valid (code_valid)
    );

endmodule

// File: rtl/twostep_adc_checker.sv
module twostep_adc_checker #(
    parameter int NUM_ENG = 2,
    parameter int FINE_W  = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      sample_req,
    input logic [NUM_ENG-1:0]        sh_hold,
    input logic [NUM_ENG*FINE_W-1:0] fine_trial,
    input logic                      code_valid,
    input logic                      overrun
);

    localparam logic [FINE_W-1:0] FIRST_TRIAL = {1'b1, {(FINE_W-1){1'b0}}};

    logic [NUM_ENG-1:0] hold_prev;
    logic [NUM_ENG-1:0] starts;

    always_ff @(posedge clk) begin
        if (!rst_n) hold_prev <= '0;
        else        hold_prev <= sh_hold;
    end

    assign starts = sh_hold & ~hold_prev;

    AST_ONE_ENGINE_STARTS: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(starts)); // R6
    AST_OVERRUN_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n) overrun |-> $past(sample_req)); // R9
    AST_OVERRUN_NO_START: assert property (@(posedge clk) disable iff (!rst_n) overrun |-> (starts == '0)); // R9

    genvar e;
    generate
        for (e = 0; e < NUM_ENG; e++) begin : g_chk
            AST_HOLD_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $rose(sh_hold[e]) |-> $past(sample_req)); // R5
            AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rst_n) $rose(sh_hold[e]) |-> (fine_trial[e*FINE_W +: FINE_W] == FIRST_TRIAL)); // R4
            AST_VALID_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $fell(sh_hold[e]) |=> code_valid); // R7
        end
    endgenerate

endmodule

bind twostep_adc_ctrl twostep_adc_checker #(
    .NUM_ENG (NUM_ENG),
    .FINE_W  (FINE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_req (sample_req),
    .sh_hold    (sh_hold),
    .fine_trial (fine_trial),
    .code_valid (code_valid),
    .overrun    (overrun)
);

// File: tb/twostep_adc_ctrl_test.sv
`timescale 1ns/1ps
module twostep_adc_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_req = 1'b0;
    logic [14:0] flash_therm = '0;
    logic [1:0]  fine_cmp;
    logic [1:0]  sh_hold;
    logic [11:0] fine_trial;
    logic [9:0]  code_out;
    logic        code_valid;
    logic        overrun;

    twostep_adc_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_req  (sample_req),
        .flash_therm (flash_therm),
        .fine_cmp    (fine_cmp),
        .sh_hold     (sh_hold),
        .fine_trial  (fine_trial),
        .code_out    (code_out),
        .code_valid  (code_valid),
        .overrun     (overrun)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    int bptr   = 0;
    logic [5:0] res_q [2] = '{6'd0, 6'd0};

    int    exp_code [$];
    int    exp_cyc  [$];
    string exp_tag  [$];

    // behavioural fine comparators: 1 when held residue >= trial level
    assign fine_cmp[0] = (res_q[0] >= fine_trial[5:0]);
    assign fine_cmp[1] = (res_q[1] >= fine_trial[11:6]);

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [14:0] therm(input int c, input int bub);
        logic [14:0] t = '0;
        for (int i = 0; i < c; i++) t[i] = 1'b1;
        if (bub >= 0) t[bub] = ~t[bub];
        return t;
    endfunction

    // driver: called at a falling edge, returns one cycle later
    task automatic pulse(input int c, input int bub, input int fine, input bit drop, input string tag);
        int s;
        int e;
        e = bptr;
        s = cyc;
        sample_req  = 1'b1;
        flash_therm = therm(c, bub);
        if (!drop) begin
            res_q[e] = 6'(fine);
            exp_code.push_back(c * 64 + fine);
            exp_cyc.push_back(s + 8);
            exp_tag.push_back(tag);
            bptr ^= 1;
        end
        @(negedge clk);
        sample_req  = 1'b0;
        flash_therm = '0;
        check("R9 overrun flag", int'(overrun), int'(drop));
        if (!drop) check("R6 engine choice", int'(sh_hold[e]), 1);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops the scoreboard on every released result
    always @(negedge clk) begin
        if (rst_n && code_valid) begin
            if (exp_code.size() == 0) begin
                check("R8 unexpected result", int'(code_out), -1);
            end else begin
                int    ec;
                int    et;
                string tg;
                ec = exp_code.pop_front();
                et = exp_cyc.pop_front();
                tg = exp_tag.pop_front();
                check(tg, int'(code_out), ec);
                check("R7 latency", cyc, et);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int hcnt;
        idle(3);
        check("R1 code_out", int'(code_out), 0);
        check("R1 code_valid", int'(code_valid), 0);
        check("R1 overrun", int'(overrun), 0);
        check("R1 sh_hold", int'(sh_hold), 0);
        check("R1 fine_trial", int'(fine_trial), 0);
        rst_n = 1'b1;
        idle(2);

        // R4 / R5: single sample on engine A, hold window and first trial
        pulse(5, -1, 37, 1'b0, "R4 fine resolve");
        check("R4 first trial", int'(fine_trial[5:0]), 32);
        hcnt = sh_hold[0] ? 1 : 0;
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            if (sh_hold[0]) hcnt++;
        end
        check("R5 hold length", hcnt, 6);

        // R2: every coarse level
        for (int c = 0; c < 16; c++) begin
            pulse(c, -1, (c * 23 + 7) % 64, 1'b0, "R2 coarse level");
            idle(9);
        end
        pulse(15, -1, 63, 1'b0, "R7 full scale");
        idle(9);
        pulse(0, -1, 0, 1'b0, "R7 zero scale");
        idle(9);

        // R3: isolated bubbles
        pulse(8, 2, 17, 1'b0, "R3 hole in ones");
        idle(9);
        pulse(3, 12, 44, 1'b0, "R3 stray one");
        idle(9);
        pulse(12, 0, 9, 1'b0, "R3 hole at bottom");
        idle(9);
        pulse(0, 14, 50, 1'b0, "R3 stray at top");
        idle(9);

        // R6 / R8: streaming every four cycles, engines alternate
        for (int k = 0; k < 8; k++) begin
            pulse(k * 2, -1, k * 7 + 1, 1'b0, "R8 stream order");
            idle(3);
        end
        idle(10);

        // R9 / R10: drops, coincident release, immediate reuse
        pulse(6, -1, 11, 1'b0, "R8 burst first");
        pulse(9, -1, 52, 1'b0, "R8 burst second");
        pulse(13, -1, 30, 1'b1, "R9 drop");
        idle(4);
        pulse(2, -1, 3, 1'b1, "R10 drop at release");
        check("R10 valid with overrun", int'(code_valid), 1);
        pulse(10, -1, 60, 1'b0, "R10 reuse after release");
        pulse(4, -1, 21, 1'b0, "R9 pointer kept");
        idle(12);
        check("R8 all results seen", exp_code.size(), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule